// File: doc/BRIEF.md
# Infrared 4PPM Transmit Framer

The block is the transmit half of a 4 Mb/s infrared serial link. It takes bytes from a transmit FIFO over a valid/ready handshake. Each byte becomes four one-hot 4-chip symbols. The block wraps the bytes in a frame made of sixteen preamble words, a start flag, the data, a CRC-32 check field and a stop flag. One chip leaves the block per clock cycle, with the most significant bit of each 16-chip word sent first. The line is dark when no frame is in progress.

The block has no separate end-of-frame command. The FIFO running empty decides how a frame ends. A runtime select input chooses between two underrun policies. With the select low, an empty FIFO closes the frame cleanly with the CRC, the stop flag and the frame pulse. With the select high, an empty FIFO aborts the frame with eight dark chips and the frame pulse. Preambles then follow until data returns, and a new frame opens at that point. Software can hold the select high for most of a frame, so that a stalled supply is seen as an abort. It then drops the select near the end, so that the last underrun closes the frame.

Every underrun sets a sticky status flag, and the same flag feeds an interrupt request. A loopback input routes the chip stream to an internal output that feeds the receive shifter, and holds the line output dark. The receive side runs on its own, so transmit and receive can be active at the same time.

Top module: `ppm_tx_framer`

## Requirements
- R1: While rst_ni is low and after its release with no data offered, line_chip_o, loop_chip_o, frame_pulse_o, tx_ready_o, underrun_o and irq_o are all 0.
- R2: A frame starts only when tx_valid_i is high. It begins with at least 16 preamble words of 0x80AA. The start flag 0x0C0C is sent once the count of 16 is reached and tx_valid_i is high. Each word is 16 chips, one chip per cycle, bit 15 first.
- R3: Each data byte becomes 16 chips. Bit pairs are taken least significant first, and each pair maps to a symbol: 00→1000, 01→0100, 10→0010, 11→0001 (leftmost chip first). Consecutive bytes follow with no gap.
- R4: The CRC is CRC-32 with reflected polynomial 0xEDB88320 and initial value 0xFFFFFFFF, taken over the data bytes of the frame. Its inverted value is sent as four bytes, least significant byte first, each encoded as in R3. The CRC restarts after every stop flag and every abort.
- R5: If the FIFO is empty when a data word ends and the sampled select is 0, the framer sends the CRC, then the stop flag 0x0CC0, then a 4-chip frame pulse slot. During that slot frame_pulse_o is 1 and the chip outputs are 0. It then returns to idle.
- R6: If the FIFO is empty when a data word ends and the sampled select is 1, the framer sends 8 zero chips and then a 4-chip frame pulse slot. It then sends preamble words until at least 16 have gone out and data is present, and then a start flag that opens a new frame.
- R7: underrun_o is set in the cycle after any underrun decision, whatever the select value. A one-cycle pulse on underrun_clr_i clears it, and a new underrun in the same cycle wins.
- R8: irq_o is high exactly when underrun_o is high and the last sampled select value is 1.
- R9: With loopback_i high, the chip stream appears on loop_chip_o and line_chip_o stays 0. With loopback_i low, the stream appears on line_chip_o and loop_chip_o stays 0.
- R10: tx_ready_o is high only in the last chip cycle of a start flag or data word, and only when tx_valid_i is high. It is never high in two consecutive cycles.
- R11: abort_on_underrun_i is sampled only at word boundaries, including every cycle while idle. The sampled value is the one the underrun decision and the interrupt mask use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Chip clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_data_i | input | 8 | Byte at the head of the transmit FIFO |
| tx_valid_i | input | 1 | FIFO holds at least one byte |
| tx_ready_o | output | 1 | Byte taken at this clock edge |
| abort_on_underrun_i | input | 1 | Underrun policy: 0 closes the frame, 1 aborts it |
| underrun_clr_i | input | 1 | Clear strobe for the underrun flag |
| loopback_i | input | 1 | Route chips to the internal receive path |
| line_chip_o | output | 1 | Chip stream to the optical driver |
| loop_chip_o | output | 1 | Chip stream to the receive shifter |
| frame_pulse_o | output | 1 | Frame pulse slot after stop flag or abort |
| underrun_o | output | 1 | Sticky underrun status |
| irq_o | output | 1 | Underrun interrupt request |

## Verification
The bench goes after the seam between the last data word and the underrun decision. A design that samples the FIFO a cycle late would accept a byte after it had already committed to the CRC, and would corrupt both the frame and the check field. An abort gap shorter than sixteen preamble words is forced on purpose, because a framer that restarts as soon as data reappears would send a short preamble. The bench flips the select while a frame is running and pulses the clear strobe on the same cycle as an underrun. A CRC that does not reset after an abort would miscompare on the very next frame. A mask applied to the flag rather than to the request would lose underrun_o whenever the select is low.

// File: rtl/ppm_tx_pkg.sv
`timescale 1ns/1ps
package ppm_tx_pkg;

  localparam int unsigned UNIT_W    = 16;
  localparam int unsigned LEN_W     = $clog2(UNIT_W + 1);
  localparam int unsigned CRC_W     = 32;
  localparam int unsigned CRC_BYTES = CRC_W / 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_START,
    ST_DATA,
    ST_CRC,
    ST_STOP,
    ST_PULSE_END,
    ST_ABORT,
    ST_PULSE_ABT
  } tx_state_e;

  // one-hot symbol, leftmost chip is the first on the line
  function automatic logic [3:0] ppm_sym(input logic [1:0] pair);
    return 4'b1000 >> pair;
  endfunction

  // least significant pair lands in the first-sent nibble
  function automatic logic [UNIT_W-1:0] ppm_byte(input logic [7:0] b);
    return {ppm_sym(b[1:0]), ppm_sym(b[3:2]), ppm_sym(b[5:4]), ppm_sym(b[7:6])};
  endfunction

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic [7:0]       d,
                                                input logic [CRC_W-1:0] poly);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ poly;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/ppm_tx_shift.sv
`timescale 1ns/1ps
module ppm_tx_shift
  import ppm_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [UNIT_W-1:0] chips_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              pulse_i,
  output logic              req_o,
  output logic              chip_o,
  output logic              pulse_o
);

  logic [UNIT_W-1:0] sh_q;
  logic [LEN_W-1:0]  left_q;
  logic              pulse_q;
  logic              busy;

  assign busy    = (left_q != '0);
  assign req_o   = (left_q <= LEN_W'(1));
  assign chip_o  = busy & sh_q[UNIT_W-1];
  assign pulse_o = busy & pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      left_q  <= '0;
      pulse_q <= 1'b0;
    end else if (load_i) begin
      sh_q    <= chips_i;
      left_q  <= len_i;
      pulse_q <= pulse_i;
    end else if (busy) begin
      sh_q   <= sh_q << 1;
      left_q <= left_q - LEN_W'(1);
      if (left_q == LEN_W'(1)) pulse_q <= 1'b0;
    end
  end

  AST_LOAD_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (left_q <= LEN_W'(1))); // R10

  AST_LEN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> busy); // R3

endmodule

// File: rtl/ppm_tx_crc.sv
`timescale 1ns/1ps
module ppm_tx_crc
  import ppm_tx_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 32'hEDB8_8320,
  parameter logic [CRC_W-1:0] INIT = 32'hFFFF_FFFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             upd_i,
  input  logic [7:0]       byte_i,
  output logic [CRC_W-1:0] fcs_o
);

  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= INIT;
    else if (clr_i)  crc_q <= INIT;
    else if (upd_i)  crc_q <= crc_step(crc_q, byte_i, POLY);
  end

  assign fcs_o = ~crc_q;

  AST_CRC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && !clr_i) |=> $stable(fcs_o)); // R4

  AST_CRC_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (fcs_o == ~INIT)); // R4

endmodule

// File: rtl/ppm_tx_seq.sv
`timescale 1ns/1ps
module ppm_tx_seq
  import ppm_tx_pkg::*;
#(
  parameter int unsigned       PRE_MIN   = 16,
  parameter logic [UNIT_W-1:0] PRE_PAT   = 16'h80AA,
  parameter logic [UNIT_W-1:0] START_PAT = 16'h0C0C,
  parameter logic [UNIT_W-1:0] STOP_PAT  = 16'h0CC0,
  parameter int unsigned       ABORT_LEN = 8,
  parameter int unsigned       PULSE_LEN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              valid_i,
  input  logic [7:0]        data_i,
  input  logic              sel_i,
  input  logic              clr_i,
  input  logic [CRC_W-1:0]  fcs_i,
  output logic              ready_o,
  output logic              load_o,
  output logic [UNIT_W-1:0] chips_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              pulse_o,
  output logic              crc_upd_o,
  output logic              crc_clr_o,
  output logic              flag_o,
  output logic              irq_o
);

  localparam int unsigned CNT_W =
    ($clog2(PRE_MIN + 1) > 2) ? $clog2(PRE_MIN + 1) : 2;

  tx_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, sel_q;
  logic             ur_evt;

  function automatic logic [7:0] fcs_byte(input logic [CRC_W-1:0] f,
                                          input logic [1:0]       k);
    case (k)
      2'd0:    return f[7:0];
      2'd1:    return f[15:8];
      2'd2:    return f[23:16];
      default: return f[31:24];
    endcase
  endfunction

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    load_o    = 1'b0;
    chips_o   = '0;
    len_o     = LEN_W'(UNIT_W);
    pulse_o   = 1'b0;
    ready_o   = 1'b0;
    crc_upd_o = 1'b0;
    crc_clr_o = 1'b0;
    ur_evt    = 1'b0;
    if (req_i) begin
      unique case (st_q)
        ST_IDLE: if (valid_i) begin
          st_d    = ST_PRE;
          cnt_d   = CNT_W'(1);
          load_o  = 1'b1;
          chips_o = PRE_PAT;
        end
        ST_PRE: begin
          load_o = 1'b1;
          if (cnt_q >= CNT_W'(PRE_MIN) && valid_i) begin
            st_d    = ST_START;
            chips_o = START_PAT;
          end else begin
            chips_o = PRE_PAT;
            if (cnt_q < CNT_W'(PRE_MIN)) cnt_d = cnt_q + CNT_W'(1);
          end
        end
        ST_START, ST_DATA: begin
          load_o = 1'b1;
          if (valid_i) begin
            ready_o   = 1'b1;
            crc_upd_o = 1'b1;
            st_d      = ST_DATA;
            chips_o   = ppm_byte(data_i);
          end else begin
            ur_evt = 1'b1;
            if (sel_i) begin
              st_d  = ST_ABORT;
              len_o = LEN_W'(ABORT_LEN);
            end else begin
              st_d    = ST_CRC;
              cnt_d   = '0;
              chips_o = ppm_byte(fcs_byte(fcs_i, 2'd0));
            end
          end
        end
        ST_CRC: begin
          load_o = 1'b1;
          if (cnt_q[1:0] == 2'(CRC_BYTES - 1)) begin
            st_d    = ST_STOP;
            chips_o = STOP_PAT;
          end else begin
            cnt_d   = cnt_q + CNT_W'(1);
            chips_o = ppm_byte(fcs_byte(fcs_i, cnt_q[1:0] + 2'd1));
          end
        end
        ST_STOP: begin
          st_d      = ST_PULSE_END;
          load_o    = 1'b1;
          len_o     = LEN_W'(PULSE_LEN);
          pulse_o   = 1'b1;
          crc_clr_o = 1'b1;
        end
        ST_PULSE_END: st_d = ST_IDLE;
        ST_ABORT: begin
          st_d      = ST_PULSE_ABT;
          load_o    = 1'b1;
          len_o     = LEN_W'(PULSE_LEN);
          pulse_o   = 1'b1;
          crc_clr_o = 1'b1;
        end
        ST_PULSE_ABT: begin
          st_d    = ST_PRE;
          cnt_d   = CNT_W'(1);
          load_o  = 1'b1;
          chips_o = PRE_PAT;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      flag_q <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (req_i)       sel_q  <= sel_i;
      if (ur_evt)      flag_q <= 1'b1;
      else if (clr_i)  flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & sel_q;

  AST_READY_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> valid_i); // R10

  AST_SINGLE_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o); // R10

  AST_FLAG_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ur_evt |=> flag_o); // R7

  AST_ABORT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ABORT && req_i) |=> (st_q == ST_PULSE_ABT)); // R6

  AST_START_AFTER_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_START && $past(st_q) != ST_START) |-> $past(st_q) == ST_PRE); // R2

endmodule

// File: rtl/ppm_tx_framer.sv
`timescale 1ns/1ps
module ppm_tx_framer
  import ppm_tx_pkg::*;
#(
  parameter int unsigned       PRE_MIN   = 16,
  parameter logic [UNIT_W-1:0] PRE_PAT   = 16'h80AA,
  parameter logic [UNIT_W-1:0] START_PAT = 16'h0C0C,
  parameter logic [UNIT_W-1:0] STOP_PAT  = 16'h0CC0,
  parameter int unsigned       ABORT_LEN = 8,
  parameter int unsigned       PULSE_LEN = 4,
  parameter logic [CRC_W-1:0]  CRC_POLY  = 32'hEDB8_8320,
  parameter logic [CRC_W-1:0]  CRC_INIT  = 32'hFFFF_FFFF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] tx_data_i,
  input  logic       tx_valid_i,
  output logic       tx_ready_o,
  input  logic       abort_on_underrun_i,
  input  logic       underrun_clr_i,
  input  logic       loopback_i,
  output logic       line_chip_o,
  output logic       loop_chip_o,
  output logic       frame_pulse_o,
  output logic       underrun_o,
  output logic       irq_o
);

  logic              req, load, pulse_ld, crc_upd, crc_clr, chip;
  logic [UNIT_W-1:0] chips;
  logic [LEN_W-1:0]  len;
  logic [CRC_W-1:0]  fcs;

  ppm_tx_seq #(
    .PRE_MIN  (PRE_MIN),
    .PRE_PAT  (PRE_PAT),
    .START_PAT(START_PAT),
    .STOP_PAT (STOP_PAT),
    .ABORT_LEN(ABORT_LEN),
    .PULSE_LEN(PULSE_LEN)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req),
    .valid_i  (tx_valid_i),
    .data_i   (tx_data_i),
    .sel_i    (abort_on_underrun_i),
    .clr_i    (underrun_clr_i),
    .fcs_i    (fcs),
    .ready_o  (tx_ready_o),
    .load_o   (load),
    .chips_o  (chips),
    .len_o    (len),
    .pulse_o  (pulse_ld),
    .crc_upd_o(crc_upd),
    .crc_clr_o(crc_clr),
    .flag_o   (underrun_o),
    .irq_o    (irq_o)
  );

  ppm_tx_crc #(
    .POLY(CRC_POLY),
    .INIT(CRC_INIT)
  ) u_crc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (crc_clr),
    .upd_i (crc_upd),
    .byte_i(tx_data_i),
    .fcs_o (fcs)
  );

  ppm_tx_shift u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .chips_i(chips),
    .len_i  (len),
    .pulse_i(pulse_ld),
    .req_o  (req),
    .chip_o (chip),
    .pulse_o(frame_pulse_o)
  );

  assign line_chip_o = chip & ~loopback_i;
  assign loop_chip_o = chip &  loopback_i;

  AST_PULSE_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_pulse_o |-> (!line_chip_o && !loop_chip_o)); // R5

endmodule

// File: tb/ppm_tx_framer_tb.sv
`timescale 1ns/1ps
module ppm_tx_framer_tb_top;

  localparam logic [15:0] PRE_PAT   = 16'h80AA;
  localparam logic [15:0] START_PAT = 16'h0C0C;
  localparam logic [15:0] STOP_PAT  = 16'h0CC0;
  localparam int M_IDLE = 0, M_PRE = 1, M_START = 2, M_DATA = 3, M_CRC = 4,
                 M_STOP = 5, M_PEND = 6, M_ABORT = 7, M_PABT = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] tx_data_i = '0;
  logic       tx_valid_i = 1'b0;
  logic       abort_on_underrun_i = 1'b0;
  logic       underrun_clr_i = 1'b0;
  logic       loopback_i = 1'b0;
  logic       tx_ready_o, line_chip_o, loop_chip_o, frame_pulse_o, underrun_o, irq_o;

  ppm_tx_framer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i),
    .tx_ready_o(tx_ready_o), .abort_on_underrun_i(abort_on_underrun_i),
    .underrun_clr_i(underrun_clr_i), .loopback_i(loopback_i),
    .line_chip_o(line_chip_o), .loop_chip_o(loop_chip_o),
    .frame_pulse_o(frame_pulse_o), .underrun_o(underrun_o), .irq_o(irq_o)
  );

  always #4 clk_i = ~clk_i;

  int unsigned n_chk = 0, n_err = 0;
  logic [7:0] fifo[$];
  bit         eq_chip[$];
  bit         eq_pulse[$];
  string      eq_tag[$];
  bit         pop_pend = 0;
  bit         sel_nx = 0, clr_nx = 0, loop_nx = 0;
  int         m_st = M_IDLE, m_cnt = 0;
  bit         m_flag = 0, m_sel = 0, m_abt = 0;
  logic [31:0] m_crc = 32'hFFFF_FFFF;
  bit         done = 0;

  function automatic logic [15:0] enc16(input logic [7:0] b);
    logic [15:0] r;
    for (int k = 0; k < 4; k++) r[15-4*k -: 4] = 4'b1000 >> b[2*k +: 2];
    return r;
  endfunction

  function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r = c;
    for (int i = 0; i < 8; i++)
      r = ((r[0] ^ d[i]) != 0) ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
    return r;
  endfunction

  task automatic push_unit(input logic [15:0] pat, input int len, input bit pl, input string tag);
    for (int i = 0; i < len; i++) begin
      eq_chip.push_back(pat[15-i]);
      eq_pulse.push_back(pl);
      eq_tag.push_back(tag);
    end
  endtask

  task automatic fail(input string tag, input string what, input int act, input int exp);
    n_err++;
    $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
  endtask

  // expected decision for the coming clock edge
  task automatic model_step(output bit exp_rdy, output bit ur);
    bit v = tx_valid_i;
    logic [31:0] fcs;
    exp_rdy = 0; ur = 0;
    if (eq_chip.size() > 1) begin
      void'(eq_chip.pop_front()); void'(eq_pulse.pop_front()); void'(eq_tag.pop_front());
      return;
    end
    if (eq_chip.size() == 1) begin
      void'(eq_chip.pop_front()); void'(eq_pulse.pop_front()); void'(eq_tag.pop_front());
    end
    m_sel = abort_on_underrun_i; // R11 sampled at boundary
    fcs = ~m_crc;
    case (m_st)
      M_IDLE: if (v) begin m_st = M_PRE; m_cnt = 1; push_unit(PRE_PAT, 16, 0, "R2"); end
      M_PRE: if (m_cnt >= 16 && v) begin
               m_st = M_START; m_abt = 0; push_unit(START_PAT, 16, 0, "R2");
             end else begin
               push_unit(PRE_PAT, 16, 0, m_abt ? "R6" : "R2");
               if (m_cnt < 16) m_cnt++;
             end
      M_START, M_DATA: if (v) begin
               exp_rdy = 1; m_crc = crc_upd(m_crc, tx_data_i); m_st = M_DATA;
               push_unit(enc16(tx_data_i), 16, 0, "R3");
             end else begin
               ur = 1;
               if (abort_on_underrun_i) begin
                 m_st = M_ABORT; m_abt = 1; push_unit(16'h0, 8, 0, "R6");
               end else begin
                 m_st = M_CRC; m_cnt = 0; push_unit(enc16(fcs[7:0]), 16, 0, "R4");
               end
             end
      M_CRC: if (m_cnt == 3) begin m_st = M_STOP; push_unit(STOP_PAT, 16, 0, "R5"); end
             else begin m_cnt++; push_unit(enc16(fcs[8*m_cnt +: 8]), 16, 0, "R4"); end
      M_STOP:  begin m_st = M_PEND; m_crc = '1; push_unit(16'h0, 4, 1, "R5"); end
      M_PEND:  m_st = M_IDLE;
      M_ABORT: begin m_st = M_PABT; m_crc = '1; push_unit(16'h0, 4, 1, "R6"); end
      M_PABT:  begin m_st = M_PRE; m_cnt = 1; push_unit(PRE_PAT, 16, 0, "R6"); end
      default: m_st = M_IDLE;
    endcase
  endtask

  task automatic tick();
    bit e_chip, e_pulse, e_rdy, ur;
    string tag;
    @(negedge clk_i);
    if (pop_pend) begin void'(fifo.pop_front()); pop_pend = 0; end
    abort_on_underrun_i = sel_nx;
    underrun_clr_i      = clr_nx; clr_nx = 0;
    loopback_i          = loop_nx;
    tx_valid_i          = fifo.size() > 0;
    tx_data_i           = (fifo.size() > 0) ? fifo[0] : 8'h00;
    #1;
    e_chip  = (eq_chip.size() > 0) ? eq_chip[0] : 1'b0;
    e_pulse = (eq_chip.size() > 0) ? eq_pulse[0] : 1'b0;
    tag     = (eq_chip.size() > 0) ? eq_tag[0] : "R2";
    if (loopback_i) tag = {tag, " R9"};
    n_chk++;
    if ({line_chip_o, loop_chip_o, frame_pulse_o} !==
        {e_chip & ~loopback_i, e_chip & loopback_i, e_pulse})
      fail(tag, "line/loop/pulse", {line_chip_o, loop_chip_o, frame_pulse_o},
           {e_chip & ~loopback_i, e_chip & loopback_i, e_pulse});
    n_chk++; // R7 R8 R11 flag and masked request
    if ({underrun_o, irq_o} !== {m_flag, m_flag & m_sel})
      fail("R7 R8 R11", "flag/irq", {underrun_o, irq_o}, {m_flag, m_flag & m_sel});
    model_step(e_rdy, ur);
    n_chk++; // R10 handshake timing
    if (tx_ready_o !== e_rdy) fail("R10", "ready", tx_ready_o, e_rdy);
    pop_pend = tx_ready_o && tx_valid_i;
    if (ur) m_flag = 1;
    else if (underrun_clr_i) m_flag = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic run_idle();
    for (int i = 0; i < 20000; i++) begin
      if (m_st == M_IDLE && eq_chip.size() == 0 && fifo.size() == 0) break;
      tick();
    end
  endtask

  task automatic push_rand(input int n);
    for (int i = 0; i < n; i++) fifo.push_back(8'($urandom));
  endtask

  initial begin
    #(8 * 190000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    // R1 reset state
    repeat (3) @(negedge clk_i);
    n_chk++;
    if ({tx_ready_o, line_chip_o, loop_chip_o, frame_pulse_o, underrun_o, irq_o} !== 6'b0)
      fail("R1", "reset outputs",
           {tx_ready_o, line_chip_o, loop_chip_o, frame_pulse_o, underrun_o, irq_o}, 0);
    rst_ni = 1'b1;
    ticks(5); // R1 idle with no data

    // clean end, fixed bytes covering all pair values
    fifo.push_back(8'h00); fifo.push_back(8'hFF); fifo.push_back(8'hE4);
    run_idle();
    clr_nx = 1; tick();

    // abort, short gap, then frame that ends cleanly after select drop
    sel_nx = 1; push_rand(2); ticks(16 * 20);
    ticks(16 * 5);
    clr_nx = 1; tick();
    push_rand(3); ticks(16 * 14);
    push_rand(4); sel_nx = 0;
    run_idle();

    // loopback frame, clear strobe on the underrun edge region
    loop_nx = 1; push_rand(5);
    for (int i = 0; i < 40 * 16; i++) begin
      if (i % 37 == 0) clr_nx = 1;
      tick();
    end
    run_idle();
    loop_nx = 0;

    // constrained random traffic
    for (int it = 0; it < 60; it++) begin
      loop_nx = ($urandom % 4) == 0;
      push_rand(1 + $urandom % 8);
      if (($urandom % 3) == 0) sel_nx = ~sel_nx;
      for (int g = 0; g < int'($urandom % 400); g++) begin
        if (($urandom % 50) == 0) clr_nx = 1;
        if (($urandom % 90) == 0) push_rand(1 + $urandom % 3);
        tick();
      end
    end
    push_rand(2); sel_nx = 0;
    run_idle();
    ticks(8);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

endmodule